// File: doc/BRIEF.md
# Video Brightness, Contrast and Saturation Adjuster

This block is one pixel-processing stage in a YUV 4:2:2 video path. Samples arrive one per cycle on a single byte lane, and a phase flag marks each one as luminance or colour-difference. On luminance samples the stage applies a contrast gain and then adds a brightness offset. On colour-difference samples it applies a saturation gain to the signed distance from mid-scale. Every result is limited to a restricted code range, so the two extreme codes never leave the stage.

The three control values are parallel inputs. Normally they are driven from registers that a host writes over a serial bus. The stage takes a new set of controls only on a line-start strobe, so a single line is always processed with one set of settings. The valid flag and the phase flag pass through with the same fixed two-cycle delay as the data.

Top module: `video_bcs_adjust`

## Requirements
- R1: On a luma sample (in_is_chroma = 0), the result before the brightness offset is (Y × contrast + 32) >> 6. The gain is a 7-bit code, where 00H gives zero, 40H gives unity and 7FH gives just under 2.
- R2: Brightness is an 8-bit offset-binary code. The signed amount (code − 128) is added to the scaled luma, so 00H gives −128, 80H gives no change and FFH gives +127.
- R3: On a chroma sample (in_is_chroma = 1), the output is 128 + floor(((C − 128) × saturation + 32) / 64). The saturation code uses the same 7-bit gain encoding as contrast.
- R4: Division by 64 rounds half up. This applies to negative chroma differences as well, so an exact half always moves toward plus infinity.
- R5: Every valid output sample, luma or chroma, is clipped to the range 1 to 254 inclusive.
- R6: A sample presented with in_valid high before clock edge k appears on out_data after edge k+1, with out_valid high and out_is_chroma equal to its input phase. A cycle with in_valid low gives out_valid low two edges later.
- R7: The control inputs are captured only in a cycle where line_start is high. That capture also applies to a sample presented in the same cycle. Changes to the control inputs in other cycles have no effect on any output.
- R8: While rst_n is low, the pipeline valid flags are cleared, so out_valid is 0. The held controls are set to brightness 80H, contrast 40H and saturation 40H, so samples taken before the first strobe pass through unchanged apart from the clip.
- R9: A contrast code of 00H makes luma output equal to clip(brightness − 128). A saturation code of 00H makes every chroma output exactly 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_start | input | 1 | One-cycle strobe that captures the control inputs |
| bright_code | input | 8 | Brightness control, offset-binary around 80H |
| contrast_code | input | 7 | Luma gain, 40H = unity |
| saturation_code | input | 7 | Chroma gain, 40H = unity |
| in_valid | input | 1 | Input sample qualifier |
| in_is_chroma | input | 1 | Input phase: 0 = luma, 1 = colour difference |
| in_data | input | 8 | Input sample |
| out_valid | output | 1 | Output sample qualifier |
| out_is_chroma | output | 1 | Output phase, delayed with the data |
| out_data | output | 8 | Adjusted and clipped sample |

## Verification
Two functions can act in the same cycle: a line-start strobe that loads new controls, and a valid sample that is already using those controls. The bench provokes this by opening every configuration with a strobe on a valid luma sample. It checks that this first sample is scaled with the new settings, not the old ones. On every cycle without a strobe, the bench drives deliberately different values on the control inputs. The expected outputs, computed arithmetically from the last strobed settings, then show whether any of those stray values reached the data.

// File: rtl/vbcs_pkg.sv
// Package: shared constants for the brightness/contrast/saturation stage.
// Assumes 8-bit samples and a 6-bit fractional gain; the widths of the
// modules themselves are carried as parameters.
package vbcs_pkg;
    typedef enum logic {
        PH_LUMA   = 1'b0,
        PH_CHROMA = 1'b1
    } vbcs_phase_e;

    localparam int CLIP_LO = 1;
    localparam int CLIP_HI = 254;
endpackage

// File: rtl/vbcs_ctrl_regs.sv
// Module: holds the three control values between line-start strobes.
// Assumes line_start is a single-cycle strobe. A strobe makes the new
// values visible at once (bypass), so a sample in the strobe cycle uses them.
module vbcs_ctrl_regs #(
    parameter int DATA_W = 8,
    parameter int GAIN_W = 7,
    parameter int FRAC_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic [DATA_W-1:0] bright_in,
    input  logic [GAIN_W-1:0] contrast_in,
    input  logic [GAIN_W-1:0] sat_in,
    output logic [DATA_W-1:0] bright_eff,
    output logic [GAIN_W-1:0] contrast_eff,
    output logic [GAIN_W-1:0] sat_eff
);
    localparam logic [DATA_W-1:0] BRIGHT_NOM = DATA_W'(1) << (DATA_W - 1);
    localparam logic [GAIN_W-1:0] GAIN_NOM   = GAIN_W'(1) << FRAC_W;

    logic [DATA_W-1:0] bright_q;
    logic [GAIN_W-1:0] contrast_q;
    logic [GAIN_W-1:0] sat_q;

    // Capture the control inputs on a strobe; load nominal values on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bright_q   <= BRIGHT_NOM;
            contrast_q <= GAIN_NOM;
            sat_q      <= GAIN_NOM;
        end else if (line_start) begin
            bright_q   <= bright_in;
            contrast_q <= contrast_in;
            sat_q      <= sat_in;
        end
    end

    // Present strobe-cycle inputs directly, otherwise the held values.
    always_comb begin
        bright_eff   = line_start ? bright_in   : bright_q;
        contrast_eff = line_start ? contrast_in : contrast_q;
        sat_eff      = line_start ? sat_in      : sat_q;
    end

    // R7
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> ($stable(bright_q) && $stable(contrast_q) && $stable(sat_q)));

    // R8
    ctrl_reset_nominal_chk: assert property (@(posedge clk)
        !rst_n |=> (bright_q == BRIGHT_NOM && contrast_q == GAIN_NOM && sat_q == GAIN_NOM));
endmodule

// File: rtl/vbcs_gain_stage.sv
// Module: first pipeline stage. It forms the signed gain product and the
// additive offset for each sample. Luma: Y*contrast with offset
// (bright - mid). Chroma: (C - mid)*saturation with offset +mid.
// Assumes gains are unsigned codes. The product width fits the worst case.
module vbcs_gain_stage #(
    parameter int DATA_W = 8,
    parameter int GAIN_W = 7,
    parameter int PROD_W = DATA_W + GAIN_W + 2,
    parameter int OFFS_W = DATA_W + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_is_chroma,
    input  logic [DATA_W-1:0]        in_data,
    input  logic [DATA_W-1:0]        bright,
    input  logic [GAIN_W-1:0]        contrast,
    input  logic [GAIN_W-1:0]        sat,
    output logic                     s1_valid,
    output logic                     s1_is_chroma,
    output logic signed [PROD_W-1:0] s1_prod,
    output logic signed [OFFS_W-1:0] s1_offset
);
    import vbcs_pkg::*;

    localparam int MID = 1 << (DATA_W - 1);

    logic signed [DATA_W:0]   operand;
    logic signed [GAIN_W:0]   gain;
    logic signed [PROD_W-1:0] prod;
    logic signed [OFFS_W-1:0] offset;

    // Choose the operand, gain and offset for the sample's phase.
    always_comb begin
        if (vbcs_phase_e'(in_is_chroma) == PH_CHROMA) begin
            operand = $signed({1'b0, in_data}) - (DATA_W+1)'(MID);
            gain    = $signed({1'b0, sat});
            offset  = OFFS_W'(MID);
        end else begin
            operand = $signed({1'b0, in_data});
            gain    = $signed({1'b0, contrast});
            offset  = $signed({2'b00, bright}) - OFFS_W'(MID);
        end
        prod = PROD_W'(operand) * PROD_W'(gain);
    end

    // Register the product, offset and sample flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid     <= 1'b0;
            s1_is_chroma <= 1'b0;
            s1_prod      <= '0;
            s1_offset    <= '0;
        end else begin
            s1_valid     <= in_valid;
            s1_is_chroma <= in_is_chroma;
            s1_prod      <= prod;
            s1_offset    <= offset;
        end
    end
endmodule

// File: rtl/vbcs_round_clip.sv
// Module: second pipeline stage. It rounds the product half-up, divides by
// 2^FRAC_W with an arithmetic shift, adds the offset and clips the sum
// to [CLIP_LO, CLIP_HI]. Assumes the sum width covers product plus offset.
module vbcs_round_clip #(
    parameter int DATA_W = 8,
    parameter int FRAC_W = 6,
    parameter int PROD_W = 17,
    parameter int OFFS_W = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     s1_valid,
    input  logic                     s1_is_chroma,
    input  logic signed [PROD_W-1:0] s1_prod,
    input  logic signed [OFFS_W-1:0] s1_offset,
    output logic                     out_valid,
    output logic                     out_is_chroma,
    output logic [DATA_W-1:0]        out_data
);
    import vbcs_pkg::*;

    localparam int SUM_W = PROD_W + 2;
    localparam int HALF  = 1 << (FRAC_W - 1);

    logic signed [SUM_W-1:0] rounded;
    logic signed [SUM_W-1:0] total;
    logic [DATA_W-1:0]       clipped;

    // Round half-up, scale down, add offset, then clip.
    always_comb begin
        rounded = (SUM_W'(s1_prod) + SUM_W'(HALF)) >>> FRAC_W;
        total   = rounded + SUM_W'(s1_offset);
        if (total < SUM_W'(CLIP_LO))
            clipped = DATA_W'(CLIP_LO);
        else if (total > SUM_W'(CLIP_HI))
            clipped = DATA_W'(CLIP_HI);
        else
            clipped = DATA_W'(total);
    end

    // Register the final sample and its flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_is_chroma <= 1'b0;
            out_data      <= '0;
        end else begin
            out_valid     <= s1_valid;
            out_is_chroma <= s1_is_chroma;
            out_data      <= clipped;
        end
    end

    // R5
    clip_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_data) >= CLIP_LO && int'(out_data) <= CLIP_HI));
endmodule

// File: rtl/video_bcs_adjust.sv
// Module: top of the brightness/contrast/saturation stage for a 4:2:2
// byte stream. There are two register stages with a fixed latency, and
// the controls are captured at line start.
// Assumes one sample per cycle at most and no back-pressure.
module video_bcs_adjust #(
    parameter int DATA_W = 8,
    parameter int GAIN_W = 7,
    parameter int FRAC_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic [DATA_W-1:0] bright_code,
    input  logic [GAIN_W-1:0] contrast_code,
    input  logic [GAIN_W-1:0] saturation_code,
    input  logic              in_valid,
    input  logic              in_is_chroma,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic              out_is_chroma,
    output logic [DATA_W-1:0] out_data
);
    localparam int PROD_W = DATA_W + GAIN_W + 2;
    localparam int OFFS_W = DATA_W + 2;

    logic [DATA_W-1:0]        bright_eff;
    logic [GAIN_W-1:0]        contrast_eff;
    logic [GAIN_W-1:0]        sat_eff;
    logic                     s1_valid;
    logic                     s1_is_chroma;
    logic signed [PROD_W-1:0] s1_prod;
    logic signed [OFFS_W-1:0] s1_offset;

    vbcs_ctrl_regs #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_start   (line_start),
        .bright_in    (bright_code),
        .contrast_in  (contrast_code),
        .sat_in       (saturation_code),
        .bright_eff   (bright_eff),
        .contrast_eff (contrast_eff),
        .sat_eff      (sat_eff)
    );

    vbcs_gain_stage #(.DATA_W(DATA_W), .GAIN_W(GAIN_W),
                      .PROD_W(PROD_W), .OFFS_W(OFFS_W)) u_gain (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_is_chroma (in_is_chroma),
        .in_data      (in_data),
        .bright       (bright_eff),
        .contrast     (contrast_eff),
        .sat          (sat_eff),
        .s1_valid     (s1_valid),
        .s1_is_chroma (s1_is_chroma),
        .s1_prod      (s1_prod),
        .s1_offset    (s1_offset)
    );

    vbcs_round_clip #(.DATA_W(DATA_W), .FRAC_W(FRAC_W),
                      .PROD_W(PROD_W), .OFFS_W(OFFS_W)) u_round (
        .clk           (clk),
        .rst_n         (rst_n),
        .s1_valid      (s1_valid),
        .s1_is_chroma  (s1_is_chroma),
        .s1_prod       (s1_prod),
        .s1_offset     (s1_offset),
        .out_valid     (out_valid),
        .out_is_chroma (out_is_chroma),
        .out_data      (out_data)
    );

    // R6
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (out_valid == $past(in_valid, 2)));

    // R6
    phase_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && out_valid) |-> (out_is_chroma == $past(in_is_chroma, 2)));

    // R8
    reset_clears_valid_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid);
endmodule

// File: tb/video_bcs_adjust_tb.sv
module video_bcs_adjust_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_start = 1'b0;
    logic [7:0] bright_code = 8'h00;
    logic [6:0] contrast_code = 7'h00;
    logic [6:0] saturation_code = 7'h00;
    logic       in_valid = 1'b0;
    logic       in_is_chroma = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       out_valid;
    logic       out_is_chroma;
    logic [7:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model of the held controls, nominal after reset (R8).
    int m_bri = 128;
    int m_con = 64;
    int m_sat = 64;

    // Two-deep expectation pipeline: index 1 is newest, index 2 is due now.
    bit    e1_v = 0, e2_v = 0;
    bit    e1_c = 0, e2_c = 0;
    int    e1_d = 0, e2_d = 0;
    string e1_t = "", e2_t = "";

    always #2 clk = ~clk;

    video_bcs_adjust u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .line_start      (line_start),
        .bright_code     (bright_code),
        .contrast_code   (contrast_code),
        .saturation_code (saturation_code),
        .in_valid        (in_valid),
        .in_is_chroma    (in_is_chroma),
        .in_data         (in_data),
        .out_valid       (out_valid),
        .out_is_chroma   (out_is_chroma),
        .out_data        (out_data)
    );

    function automatic int clip(input int v);
        if (v < 1) return 1;
        if (v > 254) return 254;
        return v;
    endfunction

    function automatic int floor_div64(input int v);
        int q;
        q = v / 64;
        if ((v % 64) != 0 && v < 0) q = q - 1;
        return q;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One cycle: check the sample that is due, then drive the next one.
    task automatic step(input bit v, input bit ph, input int d, input bit ls,
                        input int b, input int c, input int s);
        int r;
        string t;
        @(negedge clk);
        check("R6 out_valid", int'(out_valid), int'(e2_v));
        if (e2_v) begin
            check("R6 out_is_chroma", int'(out_is_chroma), int'(e2_c));
            check(e2_t, int'(out_data), e2_d);
        end
        e2_v = e1_v; e2_c = e1_c; e2_d = e1_d; e2_t = e1_t;
        // R7: only a strobe updates the model, and it applies to this sample.
        if (ls) begin m_bri = b; m_con = c; m_sat = s; end
        if (!ph) begin
            r = clip(floor_div64(d * m_con + 32) + m_bri - 128);
            t = (m_con == 0) ? "R1 R2 R4 R5 R7 R9 luma" : "R1 R2 R4 R5 R7 luma";
        end else begin
            r = clip(128 + floor_div64((d - 128) * m_sat + 32));
            t = (m_sat == 0) ? "R3 R4 R5 R7 R9 chroma" : "R3 R4 R5 R7 chroma";
        end
        e1_v = v; e1_c = ph; e1_d = r; e1_t = t;
        in_valid        = v;
        in_is_chroma    = ph;
        in_data         = 8'(d);
        line_start      = ls;
        bright_code     = 8'(b);
        contrast_code   = 7'(c);
        saturation_code = 7'(s);
    endtask

    initial begin
        int cfg_b[8] = '{8'h80, 8'h00, 8'hFF, 8'h80, 8'h80, 8'hA0, 8'h30, 8'h81};
        int cfg_c[8] = '{7'h40, 7'h40, 7'h40, 7'h00, 7'h7F, 7'h20, 7'h55, 7'h41};
        int cfg_s[8] = '{7'h40, 7'h40, 7'h40, 7'h00, 7'h7F, 7'h60, 7'h11, 7'h3F};

        // R8: valid input during reset must not produce output.
        in_valid = 1'b1;
        in_data  = 8'd77;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 out_valid in reset", int'(out_valid), 0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 out_valid after reset", int'(out_valid), 0);

        // R8: nominal controls before any strobe; stray control inputs (R7).
        for (int i = 0; i < 256; i += 17) begin
            step(1, i[0], i, 0, 8'h12, 7'h05, 7'h7A);
        end

        // Sweep each configuration; strobe lands on a valid luma sample.
        for (int k = 0; k < 8; k++) begin
            step(1, 0, 8'hC8, 1, cfg_b[k], cfg_c[k], cfg_s[k]);
            for (int y = 0; y < 256; y++) begin
                step(1, 0, y, 0, 255 - cfg_b[k], 127 - cfg_c[k], 127 - cfg_s[k]);
                if (y % 7 == 3)
                    step(0, 1, y, 0, 8'h00, 7'h7F, 7'h00);  // R6 bubble
                step(1, 1, y, 0, 8'hFF, 7'h00, 7'h7F);
            end
        end

        // Flush the pipeline.
        step(0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule